// File: doc/BRIEF.md
# Lockable Down-Counting Watchdog Timer on APB

This block is a free-running watchdog that software must keep servicing. A counter is loaded from a software-written start value and counts down by one on every clock while counting is switched on. When it runs out, it raises a timeout flag, which drives an interrupt when the interrupt is enabled, and the counter starts again from the start value. If software has still not dealt with the flag when the counter runs out a second time, and reset generation is switched on, the block raises a reset request that stays high until the block's own reset.

Software services the watchdog by either rewriting the start value, which restarts the count at once, or writing to the clear register, which drops the flag and restarts the count from the stored start value. A key register protects the configuration: one fixed key value opens write access and any other value closes it, after which writes to every other register have no effect. A test mode lets software drive both outputs straight from a test register so the wiring to the interrupt and reset controllers can be checked.

The register interface is a 32-bit APB slave that completes every transfer in its access phase, never stalls and never reports an error.

Top module: `apb_watchdog`

## Requirements
- R1: After reset the start value and the counter both read 0xFFFFFFFF, control reads 0, the lock reads 0 (unlocked), raw status reads 0 and both outputs are low.
- R2: A write to the start-value register (offset 0x000) loads the counter with the written value in the same clock; the counter (read at 0x004) decreases by one per clock while control bit 0 (offset 0x008) is 1 and holds its value while that bit is 0.
- R3: When the counter is zero and counting is on, the next clock sets the timeout flag and reloads the counter from the start value.
- R4: When the counter reaches zero with counting on, the timeout flag already set and control bit 1 equal to 1, the reset request output rises; it then stays high, even across clear writes, until presetn is asserted.
- R5: Any write to the clear register (offset 0x00C) clears the timeout flag and reloads the counter from the start value.
- R6: Raw status bit 0 (offset 0x010) shows the timeout flag whatever the control setting; masked status bit 0 (offset 0x014) and the interrupt output equal the flag ANDed with control bit 0 when test mode is off.
- R7: Writing 0x1ACCE551 to the lock register (offset 0xC00) opens write access and writing any other value closes it; the lock reads 1 in bit 0 when closed; while closed, writes to every register other than the lock are ignored.
- R8: With test-control bit 0 (offset 0xF00) set, the interrupt output follows bit 1 and the reset request output follows bit 0 of the test-output register (offset 0xF04) instead of the normal logic; clearing test-control bit 0 returns the outputs to the normal logic.
- R9: Reads of the clear register, the test-output register, misaligned or unmapped addresses return zero; pready is always 1 and pslverr always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, zero outside read transfers |
| pready | output | 1 | Always 1, no wait states |
| pslverr | output | 1 | Always 0, no error response |
| irq_o | output | 1 | Timeout interrupt |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
The counting path is tried with counting switched on for a known number of clocks and then frozen, which tells a correct one-per-clock decrement from an off-by-one or a counter that runs while disabled. Short start values with only the interrupt enabled, and then with reset generation enabled, separate the first timeout (interrupt only) from the second (reset request), and a later clear write shows the request is sticky. A run of periodic start-value rewrites shows that servicing keeps both outputs quiet, while clearing the enable after a timeout tells the raw flag apart from the masked one. Writes under a closed lock, with both the correct and a wrong key, show which registers the lock protects, and the test-mode patterns 2, 1 and 3 tell the two output bits apart.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int BUS_W  = 32;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_START  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_COUNT  = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_CLEAR  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_RAW    = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_MASKED = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_LOCK   = 12'hC00;
  localparam logic [ADDR_W-1:0] OFF_TCTRL  = 12'hF00;
  localparam logic [ADDR_W-1:0] OFF_TOUT   = 12'hF04;

  localparam logic [BUS_W-1:0] OPEN_KEY = 32'h1ACC_E551;

  typedef enum logic [3:0] {
    SEL_START,
    SEL_COUNT,
    SEL_CTRL,
    SEL_CLEAR,
    SEL_RAW,
    SEL_MASKED,
    SEL_LOCK,
    SEL_TCTRL,
    SEL_TOUT,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFF_START:  s = SEL_START;
      OFF_COUNT:  s = SEL_COUNT;
      OFF_CTRL:   s = SEL_CTRL;
      OFF_CLEAR:  s = SEL_CLEAR;
      OFF_RAW:    s = SEL_RAW;
      OFF_MASKED: s = SEL_MASKED;
      OFF_LOCK:   s = SEL_LOCK;
      OFF_TCTRL:  s = SEL_TCTRL;
      OFF_TOUT:   s = SEL_TOUT;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [BUS_W-1:0]  pwdata,
  output logic [BUS_W-1:0]  prdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              flag_i,
  output logic [CNT_W-1:0]  start_o,
  output logic              run_o,
  output logic              rst_en_o,
  output logic              locked_o,
  output logic              test_en_o,
  output logic [1:0]        test_out_o,
  output logic              reload_o,
  output logic [CNT_W-1:0]  reload_val_o,
  output logic              clr_o
);

  localparam logic [CNT_W-1:0] START_INIT = '1;

  reg_sel_e sel;
  logic     wr_acc;
  logic     wr_ok;

  logic [CNT_W-1:0] start_q, start_d;
  logic             start_ce;
  logic [1:0]       ctrl_q, ctrl_d;
  logic             ctrl_ce;
  logic             locked_q, locked_d;
  logic             lock_ce;
  logic             tctrl_q, tctrl_d;
  logic             tctrl_ce;
  logic [1:0]       tout_q, tout_d;
  logic             tout_ce;
  logic [BUS_W-1:0] rd_mux;

  assign sel    = decode_addr(paddr);
  assign wr_acc = psel && penable && pwrite;
  assign wr_ok  = wr_acc && !locked_q;

  // next-state and clock enables
  always_comb begin
    start_ce = wr_ok && (sel == SEL_START);
    start_d  = pwdata[CNT_W-1:0];
    ctrl_ce  = wr_ok && (sel == SEL_CTRL);
    ctrl_d   = pwdata[1:0];
    lock_ce  = wr_acc && (sel == SEL_LOCK);
    locked_d = (pwdata != OPEN_KEY);
    tctrl_ce = wr_ok && (sel == SEL_TCTRL);
    tctrl_d  = pwdata[0];
    tout_ce  = wr_ok && (sel == SEL_TOUT);
    tout_d   = pwdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= START_INIT;
      ctrl_q   <= 2'b00;
      locked_q <= 1'b0;
      tctrl_q  <= 1'b0;
      tout_q   <= 2'b00;
    end else begin
      if (start_ce) start_q  <= start_d;
      if (ctrl_ce)  ctrl_q   <= ctrl_d;
      if (lock_ce)  locked_q <= locked_d;
      if (tctrl_ce) tctrl_q  <= tctrl_d;
      if (tout_ce)  tout_q   <= tout_d;
    end
  end

  // counter reload requests: start-value write or clear write
  always_comb begin
    clr_o        = wr_ok && (sel == SEL_CLEAR);
    reload_o     = start_ce || clr_o;
    reload_val_o = start_ce ? start_d : start_q;
  end

  // read data
  always_comb begin
    case (sel)
      SEL_START:  rd_mux = BUS_W'(start_q);
      SEL_COUNT:  rd_mux = BUS_W'(cnt_i);
      SEL_CTRL:   rd_mux = BUS_W'(ctrl_q);
      SEL_RAW:    rd_mux = BUS_W'(flag_i);
      SEL_MASKED: rd_mux = BUS_W'(flag_i && ctrl_q[0]);
      SEL_LOCK:   rd_mux = BUS_W'(locked_q);
      SEL_TCTRL:  rd_mux = BUS_W'(tctrl_q);
      default:    rd_mux = '0;
    endcase
    prdata = (psel && !pwrite) ? rd_mux : '0;
  end

  assign start_o    = start_q;
  assign run_o      = ctrl_q[0];
  assign rst_en_o   = ctrl_q[1];
  assign locked_o   = locked_q;
  assign test_en_o  = tctrl_q;
  assign test_out_o = tout_q;

endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             rst_en_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             trip_o
);

  localparam logic [CNT_W-1:0] CNT_INIT = '1;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             trip_q, trip_d;
  logic             cnt_ce, flag_ce, trip_ce;
  logic             at_zero;
  logic             expire;

  assign at_zero = (cnt_q == '0);
  // a software reload in the same clock takes precedence over expiry
  assign expire  = run_i && at_zero && !reload_i;

  always_comb begin
    cnt_ce  = reload_i || run_i;
    flag_ce = clr_i || expire;
    trip_ce = expire && flag_q && rst_en_i;

    if (reload_i) begin
      cnt_d = reload_val_i;
    end else if (at_zero) begin
      cnt_d = start_i;
    end else begin
      cnt_d = cnt_q - CNT_ONE;
    end

    flag_d = !clr_i;
    trip_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_INIT;
      flag_q <= 1'b0;
      trip_q <= 1'b0;
    end else begin
      if (cnt_ce)  cnt_q  <= cnt_d;
      if (flag_ce) flag_q <= flag_d;
      if (trip_ce) trip_q <= trip_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
  assign trip_o = trip_q;

endmodule

// File: rtl/wdt_outsel.sv
module wdt_outsel (
  input  logic       test_en_i,
  input  logic [1:0] test_out_i,
  input  logic       flag_i,
  input  logic       run_i,
  input  logic       trip_i,
  output logic       irq_o,
  output logic       rst_req_o
);

  always_comb begin
    if (test_en_i) begin
      irq_o     = test_out_i[1];
      rst_req_o = test_out_i[0];
    end else begin
      irq_o     = flag_i && run_i;
      rst_req_o = trip_i;
    end
  end

endmodule

// File: rtl/apb_watchdog.sv
module apb_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [BUS_W-1:0]  pwdata,
  output logic [BUS_W-1:0]  prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              irq_o,
  output logic              rst_req_o
);

  logic             rst_n_sync;
  logic [CNT_W-1:0] cnt_value;
  logic [CNT_W-1:0] start_value;
  logic [CNT_W-1:0] reload_val;
  logic             tmo_flag;
  logic             run_en;
  logic             rst_en;
  logic             locked;
  logic             test_en;
  logic [1:0]       test_out;
  logic             reload_req;
  logic             clr_req;
  logic             trip;

  wdt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (pclk),
    .arst_n  (presetn),
    .rst_n_o (rst_n_sync)
  );

  wdt_regfile #(.CNT_W(CNT_W)) u_regs (
    .clk          (pclk),
    .rst_n        (rst_n_sync),
    .psel         (psel),
    .penable      (penable),
    .pwrite       (pwrite),
    .paddr        (paddr),
    .pwdata       (pwdata),
    .prdata       (prdata),
    .cnt_i        (cnt_value),
    .flag_i       (tmo_flag),
    .start_o      (start_value),
    .run_o        (run_en),
    .rst_en_o     (rst_en),
    .locked_o     (locked),
    .test_en_o    (test_en),
    .test_out_o   (test_out),
    .reload_o     (reload_req),
    .reload_val_o (reload_val),
    .clr_o        (clr_req)
  );

  wdt_core #(.CNT_W(CNT_W)) u_core (
    .clk          (pclk),
    .rst_n        (rst_n_sync),
    .run_i        (run_en),
    .rst_en_i     (rst_en),
    .start_i      (start_value),
    .reload_i     (reload_req),
    .reload_val_i (reload_val),
    .clr_i        (clr_req),
    .cnt_o        (cnt_value),
    .flag_o       (tmo_flag),
    .trip_o       (trip)
  );

  wdt_outsel u_outsel (
    .test_en_i  (test_en),
    .test_out_i (test_out),
    .flag_i     (tmo_flag),
    .run_i      (run_en),
    .trip_i     (trip),
    .irq_o      (irq_o),
    .rst_req_o  (rst_req_o)
  );

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [BUS_W-1:0]  pwdata,
  input logic [BUS_W-1:0]  prdata,
  input logic              irq_o,
  input logic              rst_req_o,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  start,
  input logic              run,
  input logic              rst_en,
  input logic              flag,
  input logic              locked,
  input logic              test_en,
  input logic [1:0]        test_out,
  input logic              trip
);

  logic wr_acc;
  logic reload_w;
  logic clear_w;

  assign wr_acc   = psel && penable && pwrite;
  assign clear_w  = wr_acc && !locked && (paddr == OFF_CLEAR);
  assign reload_w = clear_w || (wr_acc && !locked && (paddr == OFF_START));

  // R2: start-value write lands in the counter on the next clock
  p_load_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc && !locked && (paddr == OFF_START) |=> cnt == $past(pwdata[CNT_W-1:0]));

  // R2: one step down per clock while running
  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run && (cnt != '0) && !reload_w |=> cnt == $past(cnt) - CNT_W'(1));

  // R2: frozen while stopped
  p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !reload_w |=> $stable(cnt));

  // R3: expiry sets the flag and restarts from the start value
  p_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run && (cnt == '0) && !reload_w |=> flag && (cnt == $past(start)));

  // R4: request is sticky
  p_trip_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> trip);

  // R4: request only after an expiry with the flag pending and reset enabled
  p_trip_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip) |-> $past(flag && rst_en && run && (cnt == '0)));

  // R5: clear write drops the flag
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear_w |=> !flag);

  // R6: normal-mode interrupt is the masked flag
  p_irq_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |-> irq_o == (flag && run));

  // R7: closed lock protects the start value
  p_locked_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked && wr_acc && (paddr == OFF_START) |=> $stable(start));

  // R7: the key opens the lock
  p_key_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc && (paddr == OFF_LOCK) && (pwdata == OPEN_KEY) |=> !locked);

  // R8: test mode drives both outputs
  p_test_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    test_en |-> (irq_o == test_out[1]) && (rst_req_o == test_out[0]));

  // R8: normal-mode reset output follows the sticky request
  p_rst_normal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |-> rst_req_o == trip);

  // R9: clear register reads as zero
  p_clear_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    psel && !pwrite && (paddr == OFF_CLEAR) |-> prdata == '0);

endmodule

bind apb_watchdog wdt_checker #(.CNT_W(CNT_W)) u_wdt_chk (
  .clk       (pclk),
  .rst_n     (rst_n_sync),
  .psel      (psel),
  .penable   (penable),
  .pwrite    (pwrite),
  .paddr     (paddr),
  .pwdata    (pwdata),
  .prdata    (prdata),
  .irq_o     (irq_o),
  .rst_req_o (rst_req_o),
  .cnt       (cnt_value),
  .start     (start_value),
  .run       (run_en),
  .rst_en    (rst_en),
  .flag      (tmo_flag),
  .locked    (locked),
  .test_en   (test_en),
  .test_out  (test_out),
  .trip      (trip)
);

// File: tb/apb_watchdog_bench.sv
module apb_watchdog_bench;

  logic        pclk;
  logic        presetn;
  logic        psel;
  logic        penable;
  logic        pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        pready;
  logic        pslverr;
  logic        irq_o;
  logic        rst_req_o;

  int checks;
  int errors;
  int cyc;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  apb_watchdog u_apb_watchdog (
    .pclk      (pclk),
    .presetn   (presetn),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .prdata    (prdata),
    .pready    (pready),
    .pslverr   (pslverr),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );

  initial pclk = 1'b0;
  always #5 pclk = ~pclk;

  // watchdog for a hung run
  always @(posedge pclk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired actual %0d expected <= 50000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // monitor: compares read data with the scoreboard queue
  always @(negedge pclk) begin
    #1;
    if (psel && penable && !pwrite) begin
      if (exp_q.size() == 0) begin
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL scoreboard empty actual %h expected none", prdata);
      end else begin
        logic [31:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks = checks + 1;
        if (prdata !== e) begin
          errors = errors + 1;
          $display("FAIL %s read 0x%03h actual %h expected %h", t, paddr, prdata, e);
        end
      end
    end
  end

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel    = 1'b1;
    pwrite  = 1'b1;
    paddr   = a;
    pwdata  = d;
    penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel    = 1'b0;
    penable = 1'b0;
    pwrite  = 1'b0;
  endtask

  task automatic apb_rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge pclk);
    psel    = 1'b1;
    pwrite  = 1'b0;
    paddr   = a;
    penable = 1'b0;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel    = 1'b0;
    penable = 1'b0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    checks = checks + 1;
    if (act !== e) begin
      errors = errors + 1;
      $display("FAIL %s actual %b expected %b", t, act, e);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge pclk);
  endtask

  task automatic do_reset();
    presetn = 1'b0;
    wait_cyc(3);
    presetn = 1'b1;
    wait_cyc(4);
  endtask

  initial begin
    checks  = 0;
    errors  = 0;
    cyc     = 0;
    psel    = 1'b0;
    penable = 1'b0;
    pwrite  = 1'b0;
    paddr   = '0;
    pwdata  = '0;
    presetn = 1'b0;
    do_reset();

    // R1 reset state
    chk(irq_o, 1'b0, "R1 irq after reset");
    chk(rst_req_o, 1'b0, "R1 rst_req after reset");
    chk(pready, 1'b1, "R9 pready");
    chk(pslverr, 1'b0, "R9 pslverr");
    apb_rd(12'h000, 32'hFFFF_FFFF, "R1 start value");
    apb_rd(12'h004, 32'hFFFF_FFFF, "R1 counter");
    apb_rd(12'h008, 32'h0, "R1 control");
    apb_rd(12'hC00, 32'h0, "R1 lock");
    apb_rd(12'h010, 32'h0, "R1 raw status");

    // R2 load, count for 13 clocks, freeze
    apb_wr(12'h000, 32'd1000);
    apb_rd(12'h004, 32'd1000, "R2 load reaches counter");
    apb_wr(12'h008, 32'h1);
    wait_cyc(10);
    apb_wr(12'h008, 32'h0);
    apb_rd(12'h004, 32'd987, "R2 decrement count");
    apb_rd(12'h004, 32'd987, "R2 frozen when stopped");

    // R3 / R6 first timeout with interrupt only
    apb_wr(12'h000, 32'd5);
    apb_wr(12'h008, 32'h1);
    wait_cyc(8);
    chk(irq_o, 1'b1, "R3 irq after first expiry");
    chk(rst_req_o, 1'b0, "R4 no reset when disabled");
    apb_rd(12'h010, 32'h1, "R3 raw status set");
    apb_rd(12'h014, 32'h1, "R6 masked status set");
    apb_wr(12'h008, 32'h0);
    apb_rd(12'h010, 32'h1, "R6 raw status with enable off");
    apb_rd(12'h014, 32'h0, "R6 masked status with enable off");
    chk(irq_o, 1'b0, "R6 irq masked");

    // R5 clear write
    apb_wr(12'h00C, 32'hDEAD_BEEF);
    apb_rd(12'h010, 32'h0, "R5 flag cleared");
    apb_rd(12'h004, 32'd5, "R5 counter reloaded");

    // R4 second expiry raises the sticky reset request
    apb_wr(12'h000, 32'd4);
    apb_wr(12'h008, 32'h3);
    wait_cyc(7);
    chk(irq_o, 1'b1, "R4 irq after first expiry");
    chk(rst_req_o, 1'b0, "R4 no reset on first expiry");
    wait_cyc(10);
    chk(rst_req_o, 1'b1, "R4 reset on second expiry");
    apb_wr(12'h00C, 32'h1);
    wait_cyc(5);
    chk(rst_req_o, 1'b1, "R4 reset sticky across clear");
    do_reset();
    chk(rst_req_o, 1'b0, "R4 reset cleared by presetn");
    apb_rd(12'h008, 32'h0, "R1 control after second reset");

    // R2 servicing by rewriting the start value
    apb_wr(12'h000, 32'd30);
    apb_wr(12'h008, 32'h3);
    for (int i = 0; i < 10; i++) begin
      wait_cyc(5);
      apb_wr(12'h000, 32'd30);
    end
    chk(irq_o, 1'b0, "R2 serviced no irq");
    chk(rst_req_o, 1'b0, "R2 serviced no reset");
    apb_rd(12'h010, 32'h0, "R2 serviced raw status");
    apb_wr(12'h008, 32'h0);

    // R7 lock
    apb_wr(12'hC00, 32'h2BDD_F662);
    apb_rd(12'hC00, 32'h1, "R7 lock closed");
    apb_wr(12'h000, 32'h1234);
    apb_rd(12'h000, 32'd30, "R7 start write ignored");
    apb_wr(12'h008, 32'h1);
    apb_rd(12'h008, 32'h0, "R7 control write ignored");
    apb_wr(12'hF00, 32'h1);
    apb_rd(12'hF00, 32'h0, "R7 test control write ignored");
    chk(irq_o, 1'b0, "R7 irq unchanged while locked");
    apb_wr(12'hC00, 32'h1234_5678);
    apb_rd(12'hC00, 32'h1, "R7 wrong key keeps lock");
    apb_wr(12'hC00, 32'h1ACC_E551);
    apb_rd(12'hC00, 32'h0, "R7 key opens lock");
    apb_wr(12'h000, 32'h1234);
    apb_rd(12'h000, 32'h1234, "R7 start write after unlock");

    // R8 test mode
    apb_wr(12'hF00, 32'h1);
    apb_wr(12'hF04, 32'h2);
    chk(irq_o, 1'b1, "R8 test irq bit");
    chk(rst_req_o, 1'b0, "R8 test rst bit low");
    apb_wr(12'hF04, 32'h1);
    chk(irq_o, 1'b0, "R8 test irq bit low");
    chk(rst_req_o, 1'b1, "R8 test rst bit");
    apb_wr(12'hF04, 32'h3);
    chk(irq_o, 1'b1, "R8 test both irq");
    chk(rst_req_o, 1'b1, "R8 test both rst");
    apb_rd(12'hF00, 32'h1, "R8 test control readback");
    apb_rd(12'hF04, 32'h0, "R9 test output reads zero");
    apb_wr(12'hF00, 32'h0);
    chk(irq_o, 1'b0, "R8 normal irq restored");
    chk(rst_req_o, 1'b0, "R8 normal rst restored");

    // R9 zero reads
    apb_rd(12'h00C, 32'h0, "R9 clear reads zero");
    apb_rd(12'h100, 32'h0, "R9 unmapped reads zero");
    apb_rd(12'h002, 32'h0, "R9 misaligned reads zero");
    chk(pready, 1'b1, "R9 pready at end");
    chk(pslverr, 1'b0, "R9 pslverr at end");

    wait_cyc(3);
    if (exp_q.size() != 0) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL scoreboard leftover actual %0d expected 0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule